// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor core and collects five interrupt request lines. One line is non-maskable. Three lines have fixed service addresses and can each be masked. The fifth is a general request whose service address comes from an external device. The block qualifies each line against its mask bit and a global enable, and picks one winner under a fixed five-level priority. It raises a pending indication to the core. When the core starts service, the block hands back the 16-bit address where the service routine begins.

The core starts service by pulsing `take_i` while `pend_o` is high. For a fixed-address source, the address appears on `svc_vec_o` with a one-cycle `svc_vld_o` strobe on the next cycle. For the external-address source, the block first drives `ext_ack_n_o` low for one cycle. The external device places its address on `ext_vec_i` during that cycle. The block captures it and presents it with `svc_vld_o` on the cycle after. Saving the program counter and running the routine are left to the core.

The edge-captured line is detected on a rising edge and held in a sticky flag. The two level lines and the external line are sampled as levels. Accepting any request clears the global enable. The non-maskable line is honoured even while that enable is off.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the global enable is 0, the three mask bits are 1 (mask_rdata_o = 4'b0111), the edge flag is 0, ext_ack_n_o is 1, svc_vld_o is 0 and pend_o is 0.
- R2: Priority from highest to lowest is irq_nm_i, irq_edge_i, irq_lvl_a_i, irq_lvl_b_i, irq_ext_i. pend_o is 1 exactly when at least one source is eligible and no external acknowledge is in progress, and the highest eligible source is the one serviced.
- R3: irq_nm_i is eligible whenever it is high, regardless of the mask bits and the global enable.
- R4: The edge flag, irq_lvl_a_i and irq_lvl_b_i are eligible only when the global enable is 1 and their mask bit is 0. irq_ext_i needs only the global enable. The mask bit positions are: bit 2 for the edge line, bit 1 for level line A, bit 0 for level line B. A write with mask_we_i loads mask_wdata_i[2:0], and mask_rdata_o[2:0] shows the value from the next cycle.
- R5: On an accept (take_i and pend_o at a clock edge) of a fixed-address source, svc_vld_o is 1 for exactly the next cycle. svc_vec_o then holds 16'h0024 for the non-maskable line, 16'h003C for the edge line, 16'h0034 for level line A and 16'h002C for level line B.
- R6: On an accept of irq_ext_i, ext_ack_n_o is 0 for exactly the next cycle. In the cycle after that, svc_vld_o is 1 and svc_vec_o holds the value ext_vec_i had during the low cycle. ext_ack_n_o is never low at any other time.
- R7: ien_set_i sets the global enable and ien_clr_i clears it; ien_o shows the state. Any accept clears the global enable, and this takes precedence over ien_set_i.
- R8: A rising edge on irq_edge_i sets the edge flag (mask_rdata_o[3]) whatever the mask bit is. A line held high sets it only once. The level lines are not latched.
- R9: The edge flag is cleared when the edge line is serviced, or by a write with mask_wdata_i[3] = 1. A new rising edge in the same cycle as a clear leaves the flag set.
- R10: take_i with pend_o low has no effect, and no new request is accepted while an external acknowledge is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_nm_i | input | 1 | Non-maskable request, level |
| irq_edge_i | input | 1 | Maskable request, rising-edge captured |
| irq_lvl_a_i | input | 1 | Maskable request A, level |
| irq_lvl_b_i | input | 1 | Maskable request B, level |
| irq_ext_i | input | 1 | Request with externally supplied address, level |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 4 | [2:0] mask bits, [3] clears the edge flag |
| mask_rdata_o | output | 4 | [2:0] mask bits, [3] edge flag |
| ien_set_i | input | 1 | Set the global enable |
| ien_clr_i | input | 1 | Clear the global enable |
| ien_o | output | 1 | Global enable state |
| take_i | input | 1 | Core starts servicing the pending request |
| pend_o | output | 1 | A request is eligible for service |
| ext_vec_i | input | VEC_W | Address driven by the external device during acknowledge |
| ext_ack_n_o | output | 1 | Active-low acknowledge for the external-address source |
| svc_vld_o | output | 1 | One-cycle strobe: svc_vec_o is valid |
| svc_vec_o | output | VEC_W | Service routine start address |

## Verification
The bench sweeps every combination of the four level inputs, all three mask bits, the edge flag and the global enable. For each combination it computes the expected winner and address and starts service. A design with a swapped priority or a leaky mask would return the wrong address, or raise pend_o when nothing is eligible. A design that forgot that the non-maskable line ignores the enable would stay silent with the enable off. Directed cases check that the edge flag is captured while masked, that a held-high edge line is not taken twice, and that a rising edge wins over a simultaneous clear. They also check that a request arriving during the external acknowledge does not cut it short or overwrite the captured external address.

// File: rtl/prio_vec_intc_pkg.sv
package prio_vec_intc_pkg;
    localparam int NUM_SRC = 5;
    localparam int SRC_IW  = $clog2(NUM_SRC);

    // index equals priority rank, 0 is highest
    typedef enum logic [SRC_IW-1:0] {
        SRC_NM   = 3'd0,
        SRC_EDGE = 3'd1,
        SRC_LA   = 3'd2,
        SRC_LB   = 3'd3,
        SRC_EXT  = 3'd4
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } st_e;
endpackage

// File: rtl/prio_vec_intc_edge.sv
module prio_vec_intc_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] clr,
    output logic [W-1:0] hit
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] flag;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = din;
        // a fresh rising edge wins over a clear in the same cycle
        s_d.flag = (din & ~s_q.prev) | (s_q.flag & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit = s_q.flag;
endmodule

// File: rtl/prio_vec_intc_pick.sv
module prio_vec_intc_pick #(
    parameter int N = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N:0]   seen;
    logic [N-1:0] win;

    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < N; gi++) begin : g_rank
        assign seen[gi+1] = seen[gi] | req[gi];
        assign win[gi]    = req[gi] & ~seen[gi];
    end

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import prio_vec_intc_pkg::*;
#(
    parameter int               VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_NM   = 'h0024,
    parameter logic [VEC_W-1:0] VEC_EDGE = 'h003C,
    parameter logic [VEC_W-1:0] VEC_LA   = 'h0034,
    parameter logic [VEC_W-1:0] VEC_LB   = 'h002C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_nm_i,
    input  logic             irq_edge_i,
    input  logic             irq_lvl_a_i,
    input  logic             irq_lvl_b_i,
    input  logic             irq_ext_i,
    input  logic             mask_we_i,
    input  logic [3:0]       mask_wdata_i,
    output logic [3:0]       mask_rdata_o,
    input  logic             ien_set_i,
    input  logic             ien_clr_i,
    output logic             ien_o,
    input  logic             take_i,
    output logic             pend_o,
    input  logic [VEC_W-1:0] ext_vec_i,
    output logic             ext_ack_n_o,
    output logic             svc_vld_o,
    output logic [VEC_W-1:0] svc_vec_o
);
    localparam int MASK_W = 3;
    localparam int CLR_BIT = MASK_W;

    typedef struct packed {
        st_e              st;
        logic             ien;
        logic [MASK_W-1:0] mask;
        logic             svc_vld;
        logic [VEC_W-1:0] svc_vec;
    } ctl_t;

    ctl_t c_d, c_q;

    logic               edge_hit;
    logic               edge_clr;
    logic [NUM_SRC-1:0] elig;
    logic               any_elig;
    logic [SRC_IW-1:0]  pick_idx;
    src_e               win_src;
    logic               accept;
    logic [VEC_W-1:0]   fixed_vec;

    prio_vec_intc_edge #(.W(1)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_edge_i),
        .clr   (edge_clr),
        .hit   (edge_hit)
    );

    always_comb begin
        elig           = '0;
        elig[SRC_NM]   = irq_nm_i;
        elig[SRC_EDGE] = edge_hit    & ~c_q.mask[2] & c_q.ien;
        elig[SRC_LA]   = irq_lvl_a_i & ~c_q.mask[1] & c_q.ien;
        elig[SRC_LB]   = irq_lvl_b_i & ~c_q.mask[0] & c_q.ien;
        elig[SRC_EXT]  = irq_ext_i   & c_q.ien;
    end

    prio_vec_intc_pick #(.N(NUM_SRC)) u_pick (
        .req (elig),
        .any (any_elig),
        .idx (pick_idx)
    );

    assign win_src = src_e'(pick_idx);
    assign pend_o  = any_elig & (c_q.st == ST_IDLE);
    assign accept  = take_i & pend_o;

    always_comb begin
        unique case (win_src)
            SRC_NM:   fixed_vec = VEC_NM;
            SRC_EDGE: fixed_vec = VEC_EDGE;
            SRC_LA:   fixed_vec = VEC_LA;
            SRC_LB:   fixed_vec = VEC_LB;
            default:  fixed_vec = '0;
        endcase
    end

    assign edge_clr = (accept & (win_src == SRC_EDGE))
                    | (mask_we_i & mask_wdata_i[CLR_BIT]);

    always_comb begin
        c_d         = c_q;
        c_d.svc_vld = 1'b0;
        if (mask_we_i) c_d.mask = mask_wdata_i[MASK_W-1:0];
        if (ien_set_i) c_d.ien = 1'b1;
        if (ien_clr_i) c_d.ien = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    c_d.ien = 1'b0;
                    if (win_src == SRC_EXT) begin
                        c_d.st = ST_ACK;
                    end else begin
                        c_d.svc_vld = 1'b1;
                        c_d.svc_vec = fixed_vec;
                    end
                end
            end
            ST_ACK: begin
                c_d.st      = ST_IDLE;
                c_d.svc_vld = 1'b1;
                c_d.svc_vec = ext_vec_i;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st      <= ST_IDLE;
            c_q.ien     <= 1'b0;
            c_q.mask    <= '1;
            c_q.svc_vld <= 1'b0;
            c_q.svc_vec <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mask_rdata_o = {edge_hit, c_q.mask};
    assign ien_o        = c_q.ien;
    assign ext_ack_n_o  = (c_q.st != ST_ACK);
    assign svc_vld_o    = c_q.svc_vld;
    assign svc_vec_o    = c_q.svc_vec;
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_nm_i,
    input logic       irq_edge_i,
    input logic       mask_we_i,
    input logic [2:0] mask_wbits,
    input logic [3:0] mask_rdata_o,
    input logic       take_i,
    input logic       pend_o,
    input logic       ien_o,
    input logic       ext_ack_n_o,
    input logic       svc_vld_o
);
    // R6
    ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ack_n_o |=> ext_ack_n_o);

    // R6
    ack_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ack_n_o |=> svc_vld_o);

    // R5
    strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_vld_o |-> ($past(take_i) || !$past(ext_ack_n_o)));

    // R7
    accept_drops_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && pend_o) |=> !ien_o);

    // R3
    nm_always_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_nm_i && ext_ack_n_o) |-> pend_o);

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_o && !irq_nm_i) |-> !pend_o);

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_rdata_o[2:0] == $past(mask_wbits)));

    // R8
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_edge_i && !$past(irq_edge_i)) |=> mask_rdata_o[3]);

    // R10
    no_pend_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ack_n_o |-> !pend_o);
endmodule

bind prio_vec_intc prio_vec_intc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_nm_i     (irq_nm_i),
    .irq_edge_i   (irq_edge_i),
    .mask_we_i    (mask_we_i),
    .mask_wbits   (mask_wdata_i[2:0]),
    .mask_rdata_o (mask_rdata_o),
    .take_i       (take_i),
    .pend_o       (pend_o),
    .ien_o        (ien_o),
    .ext_ack_n_o  (ext_ack_n_o),
    .svc_vld_o    (svc_vld_o)
);

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             irq_nm_i, irq_edge_i, irq_lvl_a_i, irq_lvl_b_i, irq_ext_i;
    logic             mask_we_i;
    logic [3:0]       mask_wdata_i;
    logic [3:0]       mask_rdata_o;
    logic             ien_set_i, ien_clr_i, ien_o;
    logic             take_i, pend_o;
    logic [VEC_W-1:0] ext_vec_i;
    logic             ext_ack_n_o, svc_vld_o;
    logic [VEC_W-1:0] svc_vec_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_vec_intc dut (
        .clk(clk), .rst_n(rst_n),
        .irq_nm_i(irq_nm_i), .irq_edge_i(irq_edge_i),
        .irq_lvl_a_i(irq_lvl_a_i), .irq_lvl_b_i(irq_lvl_b_i), .irq_ext_i(irq_ext_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .mask_rdata_o(mask_rdata_o),
        .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .ien_o(ien_o),
        .take_i(take_i), .pend_o(pend_o),
        .ext_vec_i(ext_vec_i), .ext_ack_n_o(ext_ack_n_o),
        .svc_vld_o(svc_vld_o), .svc_vec_o(svc_vec_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        irq_nm_i = 0; irq_edge_i = 0; irq_lvl_a_i = 0; irq_lvl_b_i = 0; irq_ext_i = 0;
        mask_we_i = 0; mask_wdata_i = '0; ien_set_i = 0; ien_clr_i = 0;
        take_i = 0; ext_vec_i = '0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        tick();
        tick();
        rst_n = 1;
        tick();
    endtask

    task automatic write_mask(input logic [3:0] v);
        mask_we_i = 1; mask_wdata_i = v;
        tick();
        mask_we_i = 0; mask_wdata_i = '0;
    endtask

    task automatic set_ien();
        ien_set_i = 1;
        tick();
        ien_set_i = 0;
    endtask

    function automatic logic [15:0] exp_vec(input int s);
        case (s)
            0: return 16'h0024;
            1: return 16'h003C;
            2: return 16'h0034;
            3: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(mask_rdata_o == 4'b0111, "R1 mask/flag", 32'(mask_rdata_o), 32'h7);
        chk(ien_o == 0, "R1 enable", 32'(ien_o), 0);
        chk(ext_ack_n_o == 1, "R1 ack", 32'(ext_ack_n_o), 1);
        chk(svc_vld_o == 0, "R1 strobe", 32'(svc_vld_o), 0);
        chk(pend_o == 0, "R1 pend", 32'(pend_o), 0);

        // Sweep: R2 R3 R4 R5 R6 R7 R10
        for (int c = 0; c < 16; c++) begin
            for (int m = 0; m < 8; m++) begin
                for (int l = 0; l < 2; l++) begin
                    for (int e = 0; e < 2; e++) begin
                        bit [4:0] el;
                        int win;
                        bit p;
                        logic [15:0] xv;
                        do_reset();
                        write_mask({1'b0, 3'(m)});
                        chk(mask_rdata_o[2:0] == 3'(m), "R4 mask readback", 32'(mask_rdata_o), 32'(m));
                        if (l != 0) begin
                            irq_edge_i = 1; tick(); irq_edge_i = 0; tick();
                            chk(mask_rdata_o[3] == 1, "R8 capture regardless of mask", 32'(mask_rdata_o[3]), 1);
                        end
                        if (e != 0) set_ien();
                        irq_nm_i = c[0]; irq_lvl_a_i = c[1]; irq_lvl_b_i = c[2]; irq_ext_i = c[3];
                        #1;
                        el[0] = c[0];
                        el[1] = (l != 0) && !m[2] && (e != 0);
                        el[2] = c[1] && !m[1] && (e != 0);
                        el[3] = c[2] && !m[0] && (e != 0);
                        el[4] = c[3] && (e != 0);
                        p = |el;
                        win = 5;
                        for (int k = 4; k >= 0; k--) if (el[k]) win = k;
                        chk(pend_o == p, "R2 R3 R4 pend", 32'(pend_o), 32'(p));
                        take_i = 1;
                        tick();
                        take_i = 0;
                        if (p && win == 4) begin
                            chk(ext_ack_n_o == 0, "R6 ack low", 32'(ext_ack_n_o), 0);
                            chk(svc_vld_o == 0, "R6 no strobe yet", 32'(svc_vld_o), 0);
                            xv = 16'h4000 | 16'(c * 64 + m * 4 + l * 2 + e);
                            ext_vec_i = xv;
                            tick();
                            ext_vec_i = '0;
                            chk(svc_vld_o == 1, "R6 strobe", 32'(svc_vld_o), 1);
                            chk(svc_vec_o == xv, "R6 ext vector", 32'(svc_vec_o), 32'(xv));
                            chk(ext_ack_n_o == 1, "R6 ack release", 32'(ext_ack_n_o), 1);
                        end else if (p) begin
                            chk(svc_vld_o == 1, "R5 strobe", 32'(svc_vld_o), 1);
                            chk(svc_vec_o == exp_vec(win), "R2 R5 vector", 32'(svc_vec_o), 32'(exp_vec(win)));
                            chk(ext_ack_n_o == 1, "R6 no ack", 32'(ext_ack_n_o), 1);
                            tick();
                            chk(svc_vld_o == 0, "R5 strobe one cycle", 32'(svc_vld_o), 0);
                        end else begin
                            chk(svc_vld_o == 0 && ext_ack_n_o == 1, "R10 take ignored",
                                {30'b0, svc_vld_o, ext_ack_n_o}, 32'h1);
                        end
                        chk(ien_o == (p ? 1'b0 : 1'(e)), "R7 enable after take", 32'(ien_o), p ? 0 : e);
                        chk(mask_rdata_o[3] == ((l != 0) && !(p && win == 1)), "R9 flag after take",
                            32'(mask_rdata_o[3]), 32'((l != 0) && !(p && win == 1)));
                        clear_inputs();
                    end
                end
            end
        end

        // R8: held-high edge line taken once
        do_reset();
        write_mask(4'b0000);
        set_ien();
        irq_edge_i = 1;
        tick();
        chk(pend_o == 1, "R8 edge pending", 32'(pend_o), 1);
        take_i = 1; tick(); take_i = 0;
        chk(svc_vec_o == 16'h003C, "R8 edge vector", 32'(svc_vec_o), 32'h3C);
        set_ien();
        tick(); tick();
        chk(mask_rdata_o[3] == 0 && pend_o == 0, "R8 held high not relatched",
            {30'b0, mask_rdata_o[3], pend_o}, 0);
        irq_edge_i = 0;

        // R8: level line not latched
        irq_lvl_a_i = 1; tick(); irq_lvl_a_i = 0; #1;
        chk(pend_o == 0, "R8 level not latched", 32'(pend_o), 0);

        // R9: clear by write
        irq_edge_i = 1; tick(); irq_edge_i = 0; tick();
        write_mask(4'b1111);
        chk(mask_rdata_o == 4'b0111, "R9 clear by write", 32'(mask_rdata_o), 32'h7);

        // R9: rising edge wins over simultaneous clear
        irq_edge_i = 1; mask_we_i = 1; mask_wdata_i = 4'b1111;
        tick();
        mask_we_i = 0; irq_edge_i = 0;
        chk(mask_rdata_o[3] == 1, "R9 set wins", 32'(mask_rdata_o[3]), 1);

        // R10: no accept during external acknowledge
        do_reset();
        set_ien();
        irq_ext_i = 1; #1;
        take_i = 1; tick();
        irq_ext_i = 0;
        irq_nm_i = 1; ext_vec_i = 16'hBEEF;
        #1;
        chk(pend_o == 0, "R10 no pend during ack", 32'(pend_o), 0);
        tick();
        take_i = 0;
        chk(svc_vec_o == 16'hBEEF && ext_ack_n_o == 1, "R10 ack completes",
            32'(svc_vec_o), 32'hBEEF);
        #1;
        chk(pend_o == 1, "R3 nm pending with enable off", 32'(pend_o), 1);
        take_i = 1; tick(); take_i = 0;
        chk(svc_vec_o == 16'h0024 && ext_ack_n_o == 1, "R5 nm vector", 32'(svc_vec_o), 32'h24);
        irq_nm_i = 0;

        // R7: set then clear the enable
        set_ien();
        chk(ien_o == 1, "R7 set", 32'(ien_o), 1);
        ien_clr_i = 1; tick(); ien_clr_i = 0;
        write_mask(4'b0000);
        irq_lvl_a_i = 1; #1;
        chk(ien_o == 0 && pend_o == 0, "R7 cleared blocks", {30'b0, ien_o, pend_o}, 0);
        // R7: accept overrides a simultaneous set
        set_ien();
        take_i = 1; ien_set_i = 1; tick(); take_i = 0; ien_set_i = 0;
        chk(ien_o == 0, "R7 accept beats set", 32'(ien_o), 0);
        chk(svc_vec_o == 16'h0034, "R5 level A vector", 32'(svc_vec_o), 32'h34);
        clear_inputs();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule